// File: doc/BRIEF.md
# Bayer Per-Channel Gain Stage

This stage sits in a raw-image pipeline ahead of colour reconstruction. Pixels of a Bayer mosaic arrive one per beat on a valid/ready stream, marked with a start-of-frame flag on the first pixel and an end-of-line flag on the last pixel of each row. The stage keeps its own row and column position, combines the parity of both with a 2-bit pattern code to decide whether the pixel is a red, green or blue site, and multiplies it by the gain programmed for that colour.

Gains are unsigned fixed point with 7 fractional bits, so a value of 128 leaves a pixel unchanged; results above the largest pixel value saturate. A run-time bypass passes pixels through untouched. Configuration words are plain inputs, expected to change only while no pixels are in flight. Every accepted pixel leaves exactly two cycles later when the output is not stalled, with its frame and line flags kept beside it.

Top module: `bayer_gain_stage`

## Requirements
- R1: While reset is high and in the first cycle after it, `m_valid` is low; with no output pending `s_ready` is high.
- R2: At red sites the output uses the red gain, taken from bits 15:0 of `cfg_gain_rb`; the blue gain is bits 31:16 of the same word.
- R3: Both green sites of the 2x2 cell use the green gain, taken from bits 15:0 of `cfg_gain_gp`.
- R4: The pattern code in bits 17:16 of `cfg_gain_gp` names the first two sites of row 0 and thereby the whole cell: 0 = blue,green / green,red; 1 = green,blue / red,green; 2 = green,red / blue,green; 3 = red,green / green,blue (row 0 / row 1).
- R5: The non-bypassed output is min((pixel x gain) >> 7, 2^PIX_W - 1); a gain of 0 yields 0 and a gain of 1024 multiplies by eight before saturation.
- R6: When bit 8 of `cfg_bypass` is 1 at the time a pixel is accepted, that pixel leaves with its value unchanged, whatever the gains.
- R7: A pixel with `s_sof` high is at row 0, column 0. A row ends on `s_eol` or after the pixel at column width-1 (width = `cfg_dims` bits 15:0); the next pixel is then at column 0 of the next row, and the row after height-1 (height = `cfg_dims` bits 31:16) is row 0.
- R8: With `m_ready` high, a pixel accepted at one clock edge is presented on `m_valid`/`m_data` after the second following edge, and `m_sof`/`m_eol` equal the flags it entered with.
- R9: While `m_valid` is high and `m_ready` low, the output holds its data and flags, `s_ready` is low, and no pixel is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_gain_rb | input | 32 | Blue gain [31:16], red gain [15:0] |
| cfg_gain_gp | input | 32 | Pattern code [17:16], green gain [15:0] |
| cfg_bypass | input | 32 | Bit 8 selects pass-through |
| cfg_dims | input | 32 | Height [31:16], width [15:0] |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Stage accepts a pixel |
| s_data | input | PIX_W | Input raw pixel |
| s_sof | input | 1 | First pixel of frame |
| s_eol | input | 1 | Last pixel of line |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream accepts |
| m_data | output | PIX_W | Scaled pixel |
| m_sof | output | 1 | Delayed frame flag |
| m_eol | output | 1 | Delayed line flag |

## Verification
The bench builds the stage with 10-bit pixels and 16-bit gain fields while keeping 7 fractional bits, so a gain of 1024 on mid-range pixels drives the saturation limit of 1023 with short frames. Frame sizes are set at run time to 4x2, 3x3 and 4x4, small enough that column wrap without line flags, row wrap past the programmed height and a mid-frame restart are all reached within a few dozen beats; all four pattern codes are walked with three distinct gains so that every site mapping is told apart.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  typedef enum logic [1:0] {
    SITE_RED   = 2'd0,
    SITE_GREEN = 2'd1,
    SITE_BLUE  = 2'd2
  } site_e;

  // Bit positions of the configuration fields
  localparam int LO_FIELD_LSB  = 0;
  localparam int HI_FIELD_LSB  = 16;
  localparam int PATTERN_LSB   = 16;
endpackage

// File: rtl/bgs_site_tracker.sv
module bgs_site_tracker
  import bgs_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             sof,
  input  logic             eol,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic [1:0]       pattern,
  output site_e            site
);
  logic [DIM_W-1:0] col_q, row_q;
  logic [DIM_W-1:0] col_cur, row_cur;
  logic             line_end;
  logic             odd_row, odd_col, is_green, is_red;

  assign col_cur  = sof ? '0 : col_q;
  assign row_cur  = sof ? '0 : row_q;
  assign line_end = eol || (col_cur == width - DIM_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      row_q <= '0;
    end else if (step) begin
      if (line_end) begin
        col_q <= '0;
        row_q <= (row_cur == height - DIM_W'(1)) ? '0 : row_cur + DIM_W'(1);
      end else begin
        col_q <= col_cur + DIM_W'(1);
        row_q <= row_cur;
      end
    end
  end

  // Green lies on the diagonal selected by whether the cell starts with green.
  assign odd_row  = row_cur[0];
  assign odd_col  = col_cur[0];
  assign is_green = (odd_row ^ odd_col) ^ (pattern[1] ^ pattern[0]);
  assign is_red   = odd_row ^ pattern[1];

  always_comb begin
    if (is_green)    site = SITE_GREEN;
    else if (is_red) site = SITE_RED;
    else             site = SITE_BLUE;
  end
endmodule

// File: rtl/bgs_gain_mul.sv
module bgs_gain_mul #(
  parameter int PIX_W  = 12,
  parameter int GAIN_W = 16,
  parameter int FRAC   = 7
) (
  input  logic [PIX_W-1:0]  pix,
  input  logic [GAIN_W-1:0] gain,
  output logic [PIX_W-1:0]  result
);
  localparam int PROD_W = PIX_W + GAIN_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;

  assign prod   = PROD_W'(pix) * PROD_W'(gain);
  assign scaled = prod >> FRAC;
  assign result = (|scaled[PROD_W-1:PIX_W]) ? {PIX_W{1'b1}} : scaled[PIX_W-1:0];
endmodule

// File: rtl/bayer_gain_stage.sv
module bayer_gain_stage
  import bgs_pkg::*;
#(
  parameter int PIX_W      = 12,
  parameter int GAIN_W     = 16,
  parameter int FRAC       = 7,
  parameter int DIM_W      = 16,
  parameter int BYPASS_BIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      cfg_gain_rb,
  input  logic [31:0]      cfg_gain_gp,
  input  logic [31:0]      cfg_bypass,
  input  logic [31:0]      cfg_dims,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PIX_W-1:0] s_data,
  input  logic             s_sof,
  input  logic             s_eol,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PIX_W-1:0] m_data,
  output logic             m_sof,
  output logic             m_eol
);
  logic [GAIN_W-1:0] gain_r, gain_g, gain_b, gain_sel;
  logic [1:0]        pattern;
  logic [DIM_W-1:0]  width, height;
  logic              advance, take;
  site_e             site;

  assign gain_r  = cfg_gain_rb[LO_FIELD_LSB +: GAIN_W];
  assign gain_b  = cfg_gain_rb[HI_FIELD_LSB +: GAIN_W];
  assign gain_g  = cfg_gain_gp[LO_FIELD_LSB +: GAIN_W];
  assign pattern = cfg_gain_gp[PATTERN_LSB +: 2];
  assign width   = cfg_dims[LO_FIELD_LSB +: DIM_W];
  assign height  = cfg_dims[HI_FIELD_LSB +: DIM_W];

  logic unused_cfg;
  assign unused_cfg = ^{cfg_gain_gp[31:18], cfg_bypass};

  // Both stages move together whenever the output register can be refilled.
  assign advance = !m_valid || m_ready;
  assign s_ready = advance;
  assign take    = s_valid && advance;

  bgs_site_tracker #(.DIM_W(DIM_W)) u_track (
    .clk     (clk),
    .rst     (rst),
    .step    (take),
    .sof     (s_sof),
    .eol     (s_eol),
    .width   (width),
    .height  (height),
    .pattern (pattern),
    .site    (site)
  );

  always_comb begin
    unique case (site)
      SITE_RED:   gain_sel = gain_r;
      SITE_GREEN: gain_sel = gain_g;
      default:    gain_sel = gain_b;
    endcase
  end

  // Stage 1: captured pixel, its gain and its flags
  logic              st1_valid, st1_byp, st1_sof, st1_eol;
  logic [PIX_W-1:0]  st1_pix;
  logic [GAIN_W-1:0] st1_gain;

  always_ff @(posedge clk) begin
    if (rst) begin
      st1_valid <= 1'b0;
      st1_byp   <= 1'b0;
      st1_sof   <= 1'b0;
      st1_eol   <= 1'b0;
      st1_pix   <= '0;
      st1_gain  <= '0;
    end else if (advance) begin
      st1_valid <= s_valid;
      st1_byp   <= cfg_bypass[BYPASS_BIT];
      st1_sof   <= s_sof;
      st1_eol   <= s_eol;
      st1_pix   <= s_data;
      st1_gain  <= gain_sel;
    end
  end

  logic [PIX_W-1:0] scaled;

  bgs_gain_mul #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .FRAC(FRAC)) u_mul (
    .pix    (st1_pix),
    .gain   (st1_gain),
    .result (scaled)
  );

  // Stage 2: registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_sof   <= 1'b0;
      m_eol   <= 1'b0;
    end else if (advance) begin
      m_valid <= st1_valid;
      m_data  <= st1_byp ? st1_pix : scaled;
      m_sof   <= st1_sof;
      m_eol   <= st1_eol;
    end
  end
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
  parameter int PIX_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             s_valid,
  input logic             s_ready,
  input logic [PIX_W-1:0] s_data,
  input logic             s_sof,
  input logic             s_eol,
  input logic             byp,
  input logic             m_valid,
  input logic             m_ready,
  input logic [PIX_W-1:0] m_data,
  input logic             m_sof,
  input logic             m_eol
);
  AST_RESET_EMPTIES: assert property (@(posedge clk) rst |=> !m_valid); // R1

  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sof) && $stable(m_eol))); // R9

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> !s_ready || m_ready); // R9

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && $past(s_valid && s_ready, 2) && $past(byp, 2) && $past(m_ready, 1))
      |-> (m_valid && m_data == $past(s_data, 2))); // R6

  AST_MARKER_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && $past(s_valid && s_ready, 2) && $past(m_ready, 1))
      |-> (m_valid && m_sof == $past(s_sof, 2) && m_eol == $past(s_eol, 2))); // R8
endmodule

bind bayer_gain_stage bgs_checker #(.PIX_W(PIX_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .s_data  (s_data),
  .s_sof   (s_sof),
  .s_eol   (s_eol),
  .byp     (cfg_bypass[BYPASS_BIT]),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data),
  .m_sof   (m_sof),
  .m_eol   (m_eol)
);

// File: tb/bayer_gain_stage_tb.sv
module bayer_gain_stage_tb;
  localparam int PW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   cfg_gain_rb = '0, cfg_gain_gp = '0, cfg_bypass = '0, cfg_dims = '0;
  logic          s_valid = 1'b0, s_sof = 1'b0, s_eol = 1'b0;
  logic [PW-1:0] s_data = '0;
  logic          s_ready, m_valid, m_sof, m_eol;
  logic          m_ready = 1'b1;
  logic [PW-1:0] m_data;

  always #5 clk = ~clk;

  bayer_gain_stage #(.PIX_W(PW), .GAIN_W(16), .FRAC(7), .DIM_W(16)) u_dut (
    .clk(clk), .rst(rst), .cfg_gain_rb(cfg_gain_rb), .cfg_gain_gp(cfg_gain_gp),
    .cfg_bypass(cfg_bypass), .cfg_dims(cfg_dims), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eol(s_eol), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_sof(m_sof), .m_eol(m_eol));

  int total = 0, fails = 0;
  bit finished = 0;
  bit stall_mode = 0, hold_mode = 0;
  int gr, gg, gb, pat, wid, hgt;
  bit byp;
  int row_b = 0, col_b = 0;
  logic [PW+1:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_cfg();
    cfg_gain_rb = {gb[15:0], gr[15:0]};
    cfg_gain_gp = {14'd0, pat[1:0], gg[15:0]};
    cfg_bypass  = byp ? 32'h0000_0100 : 32'h0000_0080;
    cfg_dims    = {hgt[15:0], wid[15:0]};
  endtask

  // Site per pattern and parity: 0 red, 1 green, 2 blue
  function automatic int site_of(input int p, input int r, input int c);
    case ({p[1:0], r[0], c[0]})
      4'b00_00: return 2; 4'b00_01: return 1; 4'b00_10: return 1; 4'b00_11: return 0;
      4'b01_00: return 1; 4'b01_01: return 2; 4'b01_10: return 0; 4'b01_11: return 1;
      4'b10_00: return 1; 4'b10_01: return 0; 4'b10_10: return 2; 4'b10_11: return 1;
      default:  return (r[0] == c[0]) ? ((r[0] == 1'b0) ? 0 : 2) : 1;
    endcase
  endfunction

  function automatic int model(input int pix, input int r, input int c);
    int g, v;
    if (byp) return pix;
    g = (site_of(pat, r, c) == 0) ? gr : (site_of(pat, r, c) == 1) ? gg : gb;
    v = (pix * g) >> 7;
    return (v > 1023) ? 1023 : v;
  endfunction

  task automatic send(input int pix, input bit sof, input bit eol, input string tag);
    int r, c, e;
    @(negedge clk);
    s_valid = 1'b1; s_data = pix[PW-1:0]; s_sof = sof; s_eol = eol;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    r = sof ? 0 : row_b;
    c = sof ? 0 : col_b;
    e = model(pix, r, c);
    exp_q.push_back({sof, eol, e[PW-1:0]});
    tag_q.push_back(tag);
    @(posedge clk);
    if (eol || c == wid - 1) begin
      col_b = 0;
      row_b = (r == hgt - 1) ? 0 : r + 1;
    end else begin
      col_b = c + 1;
      row_b = r;
    end
    #1 s_valid = 1'b0;
  endtask

  task automatic send_frame(input int w, input int h, input int base, input string tag);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        send((base + r * 37 + c * 113) % 1024, (r == 0 && c == 0), (c == w - 1), tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #2;
    m_ready = hold_mode ? 1'b0 : (stall_mode ? ($urandom_range(0, 3) != 0) : 1'b1);
  end

  // Monitor: pops the scoreboard on every output transfer
  always @(negedge clk) begin
    if (!rst && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected beat", int'(m_data), -1);
      end else begin
        logic [PW+1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(m_data == e[PW-1:0], t, int'(m_data), int'(e[PW-1:0]));
        chk({m_sof, m_eol} == e[PW+1:PW], "R8 markers", int'({m_sof, m_eol}), int'(e[PW+1:PW]));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    gr = 128; gg = 128; gb = 128; pat = 3; wid = 4; hgt = 2; byp = 0;
    apply_cfg();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_valid == 1'b0, "R1 m_valid in reset", int'(m_valid), 0);
    chk(s_ready == 1'b1, "R1 s_ready in reset", int'(s_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(m_valid == 1'b0, "R1 m_valid after reset", int'(m_valid), 0);

    // R8: two-cycle latency
    send(300, 1'b1, 1'b0, "R8");
    @(negedge clk);
    chk(m_valid == 1'b0, "R8 not before second edge", int'(m_valid), 0);
    @(negedge clk);
    chk(m_valid == 1'b1, "R8 at second edge", int'(m_valid), 1);
    drain();

    // R2: only red scaled
    gr = 256; gg = 128; gb = 128; apply_cfg();
    send_frame(4, 2, 50, "R2");
    drain();
    // R3: only green scaled, both green sites
    gr = 128; gg = 64; gb = 128; apply_cfg();
    send_frame(4, 2, 90, "R3");
    drain();
    // R4: every pattern with three distinct gains
    gr = 64; gg = 192; gb = 320;
    for (int p = 0; p < 4; p++) begin
      pat = p; apply_cfg();
      send_frame(4, 2, 20 + p * 7, "R4");
      drain();
    end
    // R5: saturation and zero gain
    gr = 1024; gg = 1024; gb = 1024; pat = 1; apply_cfg();
    send_frame(4, 2, 100, "R5");
    drain();
    gr = 0; gg = 0; gb = 0; apply_cfg();
    send_frame(4, 2, 500, "R5");
    drain();
    // R6: bypass with large gains
    gr = 1024; gg = 700; gb = 5; byp = 1; apply_cfg();
    send_frame(4, 2, 333, "R6");
    drain();
    byp = 0;
    // R7: width wrap without line flags, height wrap, mid-frame restart
    gr = 64; gg = 128; gb = 256; pat = 0; wid = 3; hgt = 3; apply_cfg();
    for (int i = 0; i < 12; i++) send(200 + i * 9, (i == 0), 1'b0, "R7");
    for (int i = 0; i < 5; i++) send(400 + i * 13, (i == 0), 1'b0, "R7");
    drain();
    // R9: hold under stall, then random backpressure
    wid = 4; hgt = 4; pat = 2; apply_cfg();
    hold_mode = 1;
    repeat (2) @(negedge clk);
    send(700, 1'b1, 1'b0, "R9");
    repeat (4) @(negedge clk);
    chk(m_valid == 1'b1, "R9 valid held", int'(m_valid), 1);
    chk(m_data == exp_q[0][PW-1:0], "R9 data held", int'(m_data), int'(exp_q[0][PW-1:0]));
    chk(s_ready == 1'b0, "R9 s_ready low while stalled", int'(s_ready), 0);
    hold_mode = 0;
    drain();
    stall_mode = 1;
    send_frame(4, 4, 11, "R9");
    send_frame(4, 4, 600, "R9");
    drain();
    stall_mode = 0;
    chk(exp_q.size() == 0, "R9 all beats delivered", exp_q.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule